// File: doc/BRIEF.md
# Instruction Prefetch Bus Unit

This block is the fetch side of a processor front end that is split into a fetch unit and an execution unit. It holds a 16-bit code segment and a 16-bit fetch offset. From these it forms a 20-bit physical address, the segment times sixteen plus the offset, truncated to 20 bits. It reads 16-bit words over a simple request/ready port and stores the returned bytes in a six-entry byte queue. The execution side pops opcode bytes from the head of that queue. The unit keeps fetching while the consumer is popping, so the two sides overlap.

When the execution side takes a jump, it pulses a redirect with a new segment and offset. The queue empties at once, and fetching restarts from the new location. A read that was already on the bus when the redirect arrived still finishes, but its data is thrown away. When the offset is odd, the unit fetches a single byte, so the reads that follow are word aligned.

Top module: `prefetch_unit`

## Requirements
- R1: After reset the queue is empty (`byte_valid_o` low), the segment is FFFFh and the offset is 0000h, so the first read request addresses FFFF0h.
- R2: Every read address equals (segment << 4) + offset, truncated to 20 bits, so a sum past FFFFFh wraps to low memory.
- R3: A read of an even address pushes `mem_rdata_i[7:0]` and then `mem_rdata_i[15:8]`. Bytes leave the queue in the order they entered, and the queue holds at most 6 bytes.
- R4: A read of an odd address pushes only `mem_rdata_i[15:8]` and advances the offset by one. After that, reads are word aligned.
- R5: A read is requested only when at least two queue entries are free. With no pops, an even start fills the queue to exactly 6 bytes and an odd start to exactly 5, after which `mem_req_o` stays low.
- R6: After each completed read, the offset advances by the number of bytes pushed, modulo 65536, and the segment stays unchanged.
- R7: Once `mem_req_o` is high, it stays high with `mem_addr_o` unchanged until a cycle in which `mem_ready_i` is high. A read completes in that cycle and `mem_rdata_i` is taken in that cycle.
- R8: A redirect empties the queue, so `byte_valid_o` is low in the next cycle, and it loads the new segment and offset. The data of a read outstanding at the redirect is never queued.
- R9: A pop and the push of a completing read in the same cycle both take effect, so fetching continues while bytes are consumed.
- R10: A pop while the queue is empty is ignored and loses no later byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Flush the queue and load a new fetch location |
| redirect_seg_i | input | 16 | New code segment on redirect |
| redirect_off_i | input | 16 | New fetch offset on redirect |
| mem_req_o | output | 1 | Read request, held until ready |
| mem_addr_o | output | 20 | Physical byte address of the read |
| mem_ready_i | input | 1 | Read completes this cycle; data valid |
| mem_rdata_i | input | 16 | Read word; the even byte is in bits 7:0 |
| byte_valid_o | output | 1 | Queue head holds a byte |
| byte_data_o | output | 8 | Byte at the queue head |
| byte_pop_i | input | 1 | Remove the head byte at this clock edge |

## Verification
The bench drives a memory model whose byte values are a function of the address. It sweeps segments and offsets that include odd starts, an offset of FFFEh or FFFFh, and segment sums past the 1 MB boundary. It combines these with several read latencies and pop rates, and compares every popped byte against the expected physical address. The following faults each show up as a wrong byte or a byte out of order:
- a missing wrap, in the offset or in the 20-bit address;
- swapped byte lanes;
- a word fetch from an odd address.

The bench lands redirects while a read is stalled on the bus. A design that queued the stale data would hand out bytes from the old location. With the memory frozen, the bench drains the queue and counts what is left. A unit that fetched with only one free entry would overflow or count wrong, and pops issued into an empty queue would lose a byte.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    // Number of bytes a completing read deposits in the queue.
    typedef enum logic [1:0] {
        PUSH_NONE = 2'd0,
        PUSH_ONE  = 2'd1,
        PUSH_TWO  = 2'd2
    } push_e;

endpackage

// File: rtl/pfu_addr_gen.sv
module pfu_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  phys_o
);

    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] off_ext;

    // The carry out of the top bit is dropped, so addresses wrap.
    always_comb begin
        base_ext = {seg_i, {SHIFT{1'b0}}};
        off_ext  = PA_W'(off_i);
        phys_o   = base_ext + off_ext;
    end

endmodule

// File: rtl/pfu_byte_fifo.sv
module pfu_byte_fifo
    import pfu_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int W     = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  push_e            push_i,
    input  logic [W-1:0]     din0_i,
    input  logic [W-1:0]     din1_i,
    input  logic             pop_i,
    output logic             valid_o,
    output logic [W-1:0]     dout_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_s;

    fifo_s fifo_d, fifo_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    logic             do_pop;
    logic [1:0]       npush;
    logic [PTR_W-1:0] wr_next1;

    always_comb begin
        fifo_d   = fifo_q;
        do_pop   = pop_i && (fifo_q.cnt != '0);
        npush    = push_i;
        wr_next1 = ptr_inc(fifo_q.wr);
        if (flush_i) begin
            fifo_d.rd  = '0;
            fifo_d.wr  = '0;
            fifo_d.cnt = '0;
        end else begin
            if (push_i != PUSH_NONE) begin
                fifo_d.mem[fifo_q.wr] = din0_i;
                fifo_d.wr = wr_next1;
            end
            if (push_i == PUSH_TWO) begin
                fifo_d.mem[wr_next1] = din1_i;
                fifo_d.wr = ptr_inc(wr_next1);
            end
            if (do_pop) begin
                fifo_d.rd = ptr_inc(fifo_q.rd);
            end
            fifo_d.cnt = fifo_q.cnt + CNT_W'(npush) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    always_comb begin
        valid_o = (fifo_q.cnt != '0);
        dout_o  = fifo_q.mem[fifo_q.rd];
        count_o = fifo_q.cnt;
    end

    // R3: occupancy never exceeds the queue depth
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_o) <= DEPTH);

    // R10: a pop on an empty queue leaves it empty
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && pop_i && push_i == PUSH_NONE && !flush_i) |=> (count_o == '0));

    // R9: simultaneous push and pop both count
    p_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && valid_o && pop_i && push_i != PUSH_NONE)
        |=> (int'(count_o) == int'($past(count_o)) + int'($past(npush)) - 1));

endmodule

// File: rtl/prefetch_unit.sv
module prefetch_unit
    import pfu_pkg::*;
#(
    parameter int              SEG_W     = 16,
    parameter int              OFF_W     = 16,
    parameter int              SHIFT     = 4,
    parameter int              BUS_W     = 16,
    parameter int              QDEPTH    = 6,
    parameter logic [15:0]     RESET_SEG = 16'hFFFF,
    parameter logic [15:0]     RESET_OFF = 16'h0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   redirect_i,
    input  logic [SEG_W-1:0]       redirect_seg_i,
    input  logic [OFF_W-1:0]       redirect_off_i,
    output logic                   mem_req_o,
    output logic [SEG_W+SHIFT-1:0] mem_addr_o,
    input  logic                   mem_ready_i,
    input  logic [BUS_W-1:0]       mem_rdata_i,
    output logic                   byte_valid_o,
    output logic [7:0]             byte_data_o,
    input  logic                   byte_pop_i
);

    localparam int PA_W  = SEG_W + SHIFT;
    localparam int CNT_W = $clog2(QDEPTH + 1);
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic             busy;
        logic             stale;
        logic             single;
        logic [PA_W-1:0]  addr;
    } fetch_s;

    fetch_s st_d, st_q;

    logic [PA_W-1:0]   phys_w;
    logic [CNT_W-1:0]  q_count;
    push_e             push_w;
    logic [BYTE_W-1:0] din0_w;
    logic [BYTE_W-1:0] din1_w;
    logic              accept_w;
    logic              room_w;

    pfu_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_agen (
        .seg_i  (st_q.seg),
        .off_i  (st_q.off),
        .phys_o (phys_w)
    );

    always_comb begin
        st_d     = st_q;
        push_w   = PUSH_NONE;
        accept_w = st_q.busy && mem_ready_i;
        room_w   = int'(q_count) <= QDEPTH - 2;
        din0_w   = st_q.single ? mem_rdata_i[BUS_W-1 -: BYTE_W] : mem_rdata_i[BYTE_W-1:0];
        din1_w   = mem_rdata_i[BUS_W-1 -: BYTE_W];

        if (accept_w) begin
            st_d.busy  = 1'b0;
            st_d.stale = 1'b0;
            if (!st_q.stale && !redirect_i) begin
                push_w   = st_q.single ? PUSH_ONE : PUSH_TWO;
                st_d.off = st_q.off + (st_q.single ? OFF_W'(1) : OFF_W'(2));
            end
        end

        if (redirect_i) begin
            st_d.seg   = redirect_seg_i;
            st_d.off   = redirect_off_i;
            st_d.stale = st_q.busy && !accept_w;
        end else if (!st_q.busy && room_w) begin
            st_d.busy   = 1'b1;
            st_d.addr   = phys_w;
            st_d.single = st_q.off[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.seg    <= SEG_W'(RESET_SEG);
            st_q.off    <= OFF_W'(RESET_OFF);
        end else begin
            st_q <= st_d;
        end
    end

    pfu_byte_fifo #(
        .DEPTH (QDEPTH),
        .W     (BYTE_W),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (redirect_i),
        .push_i  (push_w),
        .din0_i  (din0_w),
        .din1_i  (din1_w),
        .pop_i   (byte_pop_i),
        .valid_o (byte_valid_o),
        .dout_o  (byte_data_o),
        .count_o (q_count)
    );

    always_comb begin
        mem_req_o  = st_q.busy;
        mem_addr_o = st_q.addr;
    end

    // R7: request and address held until the memory is ready
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R8: a redirect leaves the queue empty in the next cycle
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> !byte_valid_o);

    // R5: a read starts only with two or more free entries
    p_issue_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> (int'(q_count) <= QDEPTH - 2));

endmodule

// File: tb/tb_prefetch_unit.sv
`timescale 1ns/1ps
module tb_prefetch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_i = 1'b0;
    logic [15:0] redirect_seg_i = '0;
    logic [15:0] redirect_off_i = '0;
    logic        mem_req_o;
    logic [19:0] mem_addr_o;
    logic        mem_ready_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic        byte_valid_o;
    logic [7:0]  byte_data_o;
    logic        byte_pop_i = 1'b0;

    always #2.5 clk = ~clk;

    prefetch_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .redirect_i     (redirect_i),
        .redirect_seg_i (redirect_seg_i),
        .redirect_off_i (redirect_off_i),
        .mem_req_o      (mem_req_o),
        .mem_addr_o     (mem_addr_o),
        .mem_ready_i    (mem_ready_i),
        .mem_rdata_i    (mem_rdata_i),
        .byte_valid_o   (byte_valid_o),
        .byte_data_o    (byte_data_o),
        .byte_pop_i     (byte_pop_i)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int lat = 0;
    bit stall = 0;
    int waitc = 0;
    bit prev_req = 0;
    bit prev_ready = 0;
    logic [19:0] prev_addr = '0;

    bit pop_en = 0;
    int period = 1;
    int cyc = 0;
    int npop = 0;
    int overlap = 0;
    logic [15:0] exp_seg = 16'hFFFF;
    logic [15:0] exp_off = 16'h0000;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: byte value depends on address; R7 hold check
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready_i = 1'b0;
            waitc = 0;
        end else begin
            if (prev_req && !prev_ready)
                chk(mem_req_o && mem_addr_o == prev_addr, "R7", {11'd0, mem_req_o, mem_addr_o}, {12'd1, prev_addr});
            if (mem_req_o && !stall) begin
                if (waitc >= lat) begin
                    mem_ready_i = 1'b1;
                    mem_rdata_i = {mem_byte({mem_addr_o[19:1], 1'b1}), mem_byte({mem_addr_o[19:1], 1'b0})};
                    waitc = 0;
                end else begin
                    mem_ready_i = 1'b0;
                    waitc++;
                end
            end else begin
                mem_ready_i = 1'b0;
                if (!mem_req_o) waitc = 0;
            end
        end
        prev_req = mem_req_o;
        prev_ready = mem_ready_i;
        prev_addr = mem_addr_o;
    end

    task automatic step();
        @(negedge clk);
        #1;
        cyc++;
        if (pop_en && byte_valid_o && (cyc % period == 0)) begin
            chk(byte_data_o == mem_byte(phys_of(exp_seg, exp_off)), "R2 R3 R4 R6",
                {24'd0, byte_data_o}, {24'd0, mem_byte(phys_of(exp_seg, exp_off))});
            exp_off = exp_off + 16'd1;
            npop++;
            byte_pop_i = 1'b1;
            if (mem_req_o && mem_ready_i) overlap++;
        end else begin
            byte_pop_i = 1'b0;
        end
    endtask

    task automatic redirect(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        #1;
        byte_pop_i = 1'b0;
        redirect_i = 1'b1;
        redirect_seg_i = s;
        redirect_off_i = o;
        exp_seg = s;
        exp_off = o;
        @(negedge clk);
        #1;
        redirect_i = 1'b0;
        chk(!byte_valid_o, "R8", {31'd0, byte_valid_o}, 32'd0);
    endtask

    task automatic consume(input int n);
        int target;
        target = npop + n;
        pop_en = 1;
        for (int i = 0; i < 600 && npop < target; i++) step();
        chk(npop >= target, "R9", npop, target);
        pop_en = 0;
        step();
    endtask

    task automatic drain(output int got);
        int start;
        start = npop;
        pop_en = 1;
        period = 1;
        for (int i = 0; i < 20; i++) step();
        pop_en = 0;
        step();
        got = npop - start;
    endtask

    initial begin
        int got;
        logic [15:0] segs [5];
        logic [15:0] offs [5];
        segs = '{16'h0000, 16'hFFFF, 16'hF000, 16'h0001, 16'h8421};
        offs = '{16'h0000, 16'h0001, 16'hFFFE, 16'hFFFF, 16'h7FFF};

        repeat (3) @(negedge clk);
        chk(!byte_valid_o && !mem_req_o, "R1", {30'd0, byte_valid_o, mem_req_o}, 32'd0);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 10 && !mem_req_o; i++) step();
        chk(mem_req_o && mem_addr_o == 20'hFFFF0, "R1", {12'd0, mem_addr_o}, 32'hFFFF0);

        // Stream across the 1 MB wrap at full pop rate
        lat = 0; period = 1;
        consume(40);
        chk(overlap > 0, "R9", overlap, 1);

        // Fill without popping: request must stop
        for (int i = 0; i < 30; i++) step();
        chk(!mem_req_o, "R5", {31'd0, mem_req_o}, 32'd0);

        // Redirect from idle: exact address of the first read
        redirect(16'h1234, 16'h5678);
        step();
        chk(mem_req_o && mem_addr_o == 20'h179B8, "R2", {12'd0, mem_addr_o}, 32'h179B8);
        for (int i = 0; i < 30; i++) step();
        chk(!mem_req_o, "R5", {31'd0, mem_req_o}, 32'd0);
        stall = 1;
        drain(got);
        chk(got == 6, "R5", got, 6);

        // Redirect with a stalled read in flight, then pops into an empty queue
        redirect(16'hABCD, 16'h0003);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            byte_pop_i = 1'b1;
            chk(!byte_valid_o, "R10", {31'd0, byte_valid_o}, 32'd0);
        end
        @(negedge clk);
        #1;
        byte_pop_i = 1'b0;
        stall = 0;
        for (int i = 0; i < 30; i++) step();
        stall = 1;
        drain(got);
        chk(got == 5, "R4 R5", got, 5);

        // Sweep latency, pop rate and start location
        stall = 0;
        for (int li = 0; li < 4; li++) begin
            for (int pi = 1; pi <= 3; pi++) begin
                for (int k = 0; k < 5; k++) begin
                    lat = li;
                    period = pi;
                    redirect(segs[(k + li) % 5], offs[k]);
                    consume(14);
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule